// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps the sharer record for each line tracked by a home directory. It does not hold a full presence vector per line. Each entry has a small number of processor-id slots, `NUM_PTR` of them, each `log2(NUM_PROC)` bits wide, and each slot has its own valid flag. A caller sends one command per handshake. The command names an entry index, a processor id and an operation: record a sharer, drop a sharer, or a write by that processor. A write yields the set of caches that must be invalidated. These targets leave the block one per handshake on a valid/ready port, followed by a one-cycle done pulse. The block stores no data and moves no messages.

An entry can run out of slots. The elaboration parameter `OVF` then decides what happens. In coarse mode, the slot storage is reused as a vector with one bit per group of `CLUSTER` consecutive processors. In replacement mode, a slot chosen round-robin is evicted and its owner is invalidated. In broadcast mode, the entry is marked so that the next write invalidates every processor. After any write, the entry returns to pointer mode and holds only the writer.

Top module: `dir_limptr`

## Requirements
- R1: While reset is low and after it rises, every entry is empty in pointer mode, `cmd_ready_o` is 1, and `inv_valid_o` and `inv_done_o` are 0. A write to an entry that has seen no command since reset yields no target, only the done pulse.
- R2: Op code 1 (add) on a pointer-mode entry with a free slot records the processor and emits nothing. Adding a processor that is already recorded has no effect.
- R3: Op code 2 (remove) on a pointer-mode entry clears the slot holding that processor, and the slot can be reused by a later add without overflow. Removing an absent processor has no effect.
- R4: Op code 3 (write) emits every recorded sharer except the writer, in ascending id order, one per cycle in which `inv_valid_o` and `inv_ready_i` are both high. `inv_done_o` is high for exactly one cycle after the last target, or two cycles after acceptance when there are no targets. Afterwards the entry holds only the writer. Op code 0 does nothing.
- R5: With `OVF`=coarse, adding a new processor to a full pointer entry emits nothing and converts the entry. Bit c of the coarse vector stands for processors c·CLUSTER to c·CLUSTER+CLUSTER-1, and the bits set are those of all prior sharers and the new one. Later adds set their group bit, and removes are ignored. A write then invalidates every processor in a marked group except the writer.
- R6: With `OVF`=replace, adding a new processor to a full entry evicts the slot named by a per-entry round-robin index. That index is 0 after reset or a write and advances by one per eviction, wrapping at `NUM_PTR`. The evicted processor is emitted as the only target, followed by done, and the new processor takes its slot.
- R7: With `OVF`=broadcast, overflow emits nothing, later adds change nothing, and the next write invalidates all processors except the writer.
- R8: `cmd_ready_o` is low from the cycle after a write or eviction is accepted until after the done pulse. While `inv_valid_o` is high and `inv_ready_i` is low, the target stays valid and unchanged.
- R9: A command changes only the entry it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_op_i | input | 2 | 0 none, 1 add, 2 remove, 3 write |
| cmd_idx_i | input | log2(NUM_ENTRY) | Entry index |
| cmd_proc_i | input | log2(NUM_PROC) | Processor id (sharer or writer) |
| inv_valid_o | output | 1 | Invalidation target present |
| inv_ready_i | input | 1 | Target consumed |
| inv_proc_o | output | log2(NUM_PROC) | Processor to invalidate |
| inv_done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions check the port protocol on every cycle: a stalled target stays stable, commands are refused while targets drain, done is a single-cycle pulse that never overlaps a target, targets within one sequence rise strictly, and the outputs are idle under reset. The actual contents of the sharer sets only show up in the bench's scenarios. These cover duplicate and absent-id commands, slot reuse after removal, conversion to groups, round-robin victims across a write, broadcast marking, entry isolation and reset during use. In each scenario a later write exposes the stored state as a set of targets.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {OVF_COARSE, OVF_REPLACE, OVF_BCAST} ovf_e;
  typedef enum logic [1:0] {OP_NOP = 2'd0, OP_ADD = 2'd1, OP_REM = 2'd2, OP_WR = 2'd3} op_e;
  typedef enum logic [1:0] {EM_IDLE, EM_RUN, EM_DONE} em_st_e;
endpackage

// File: rtl/dir_entry_next.sv
module dir_entry_next import dir_pkg::*; #(
  parameter int unsigned NUM_PROC = 16,
  parameter int unsigned NUM_PTR  = 4,
  parameter int unsigned CLUSTER  = 4,
  parameter ovf_e        OVF      = OVF_COARSE,
  localparam int unsigned LG  = $clog2(NUM_PROC),
  localparam int unsigned W   = NUM_PTR * LG,
  localparam int unsigned RRW = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic                mode_i,
  input  logic [NUM_PTR-1:0]  vld_i,
  input  logic [W-1:0]        word_i,
  input  logic [RRW-1:0]      rr_i,
  input  op_e                 op_i,
  input  logic [LG-1:0]       proc_i,
  output logic                mode_o,
  output logic [NUM_PTR-1:0]  vld_o,
  output logic [W-1:0]        word_o,
  output logic [RRW-1:0]      rr_o,
  output logic                emit_o,
  output logic [NUM_PROC-1:0] mask_o
);
  localparam int unsigned NCL = NUM_PROC / CLUSTER;
  localparam logic [RRW-1:0] RR_LAST = RRW'(NUM_PTR - 1);

  logic           hit, free_any;
  logic [RRW-1:0] free_idx;
  logic [NCL-1:0] occ;

  always_comb begin
    hit = 1'b0; free_any = 1'b0; free_idx = '0; occ = '0;
    for (int s = 0; s < NUM_PTR; s++)
      if (vld_i[s]) begin
        if (word_i[s*LG +: LG] == proc_i) hit = 1'b1;
        occ[word_i[s*LG +: LG] / CLUSTER] = 1'b1;
      end
    for (int s = NUM_PTR - 1; s >= 0; s--)
      if (!vld_i[s]) begin free_any = 1'b1; free_idx = RRW'(s); end
  end

  always_comb begin
    mode_o = mode_i; vld_o = vld_i; word_o = word_i; rr_o = rr_i;
    emit_o = 1'b0; mask_o = '0;
    unique case (op_i)
      OP_ADD: begin
        if (mode_i) begin
          if (OVF == OVF_COARSE) word_o[proc_i / CLUSTER] = 1'b1;
        end else if (!hit) begin
          if (free_any) begin
            word_o[free_idx*LG +: LG] = proc_i;
            vld_o[free_idx]           = 1'b1;
          end else if (OVF == OVF_REPLACE) begin
            emit_o = 1'b1;
            mask_o[word_i[rr_i*LG +: LG]] = 1'b1;
            word_o[rr_i*LG +: LG] = proc_i;
            rr_o = (rr_i == RR_LAST) ? '0 : rr_i + 1'b1;
          end else begin
            // storage reinterpreted as group vector
            mode_o = 1'b1; vld_o = '0; word_o = '0;
            if (OVF == OVF_COARSE) word_o[NCL-1:0] = occ | (NCL'(1) << (proc_i / CLUSTER));
            else                   word_o[NCL-1:0] = '1;
          end
        end
      end
      OP_REM: begin
        if (!mode_i)
          for (int s = 0; s < NUM_PTR; s++)
            if (vld_i[s] && word_i[s*LG +: LG] == proc_i) vld_o[s] = 1'b0;
      end
      OP_WR: begin
        emit_o = 1'b1;
        if (mode_i) begin
          for (int p = 0; p < NUM_PROC; p++) mask_o[p] = word_i[p / CLUSTER];
        end else begin
          for (int s = 0; s < NUM_PTR; s++)
            if (vld_i[s]) mask_o[word_i[s*LG +: LG]] = 1'b1;
        end
        mask_o[proc_i] = 1'b0;
        mode_o = 1'b0; vld_o = '0; vld_o[0] = 1'b1;
        word_o = '0; word_o[LG-1:0] = proc_i; rr_o = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_inv_emit.sv
module dir_inv_emit import dir_pkg::*; #(
  parameter int unsigned NUM_PROC = 16,
  localparam int unsigned LG = $clog2(NUM_PROC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NUM_PROC-1:0] mask_i,
  output logic                busy_o,
  output logic                inv_valid_o,
  input  logic                inv_ready_i,
  output logic [LG-1:0]       inv_proc_o,
  output logic                done_o
);
  em_st_e              st_q;
  logic [NUM_PROC-1:0] pend_q, pend_clr;
  logic [LG-1:0]       low;

  always_comb begin
    low = '0;
    for (int p = NUM_PROC - 1; p >= 0; p--)
      if (pend_q[p]) low = LG'(p);
    pend_clr = pend_q & ~(NUM_PROC'(1) << low);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= EM_IDLE; pend_q <= '0;
    end else begin
      unique case (st_q)
        EM_IDLE: if (start_i) begin pend_q <= mask_i; st_q <= EM_RUN; end
        EM_RUN: begin
          if (pend_q == '0) st_q <= EM_DONE;
          else if (inv_ready_i) begin
            pend_q <= pend_clr;
            if (pend_clr == '0) st_q <= EM_DONE;
          end
        end
        EM_DONE: st_q <= EM_IDLE;
        default: st_q <= EM_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != EM_IDLE);
  assign inv_valid_o = (st_q == EM_RUN) && (pend_q != '0);
  assign inv_proc_o  = low;
  assign done_o      = (st_q == EM_DONE);
endmodule

// File: rtl/dir_limptr.sv
module dir_limptr import dir_pkg::*; #(
  parameter int unsigned NUM_PROC  = 16,
  parameter int unsigned NUM_PTR   = 4,
  parameter int unsigned CLUSTER   = 4,
  parameter int unsigned NUM_ENTRY = 8,
  parameter ovf_e        OVF       = OVF_COARSE,
  localparam int unsigned LG   = $clog2(NUM_PROC),
  localparam int unsigned IDXW = $clog2(NUM_ENTRY)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  input  logic [1:0]      cmd_op_i,
  input  logic [IDXW-1:0] cmd_idx_i,
  input  logic [LG-1:0]   cmd_proc_i,
  output logic            inv_valid_o,
  input  logic            inv_ready_i,
  output logic [LG-1:0]   inv_proc_o,
  output logic            inv_done_o
);
  localparam int unsigned W   = NUM_PTR * LG;
  localparam int unsigned RRW = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  logic               mode_q [NUM_ENTRY];
  logic [NUM_PTR-1:0] vld_q  [NUM_ENTRY];
  logic [W-1:0]       word_q [NUM_ENTRY];
  logic [RRW-1:0]     rr_q   [NUM_ENTRY];

  logic                n_mode, emit, busy, acc;
  logic [NUM_PTR-1:0]  n_vld;
  logic [W-1:0]        n_word;
  logic [RRW-1:0]      n_rr;
  logic [NUM_PROC-1:0] mask;

  assign cmd_ready_o = !busy;
  assign acc         = cmd_valid_i && cmd_ready_o;

  dir_entry_next #(.NUM_PROC(NUM_PROC), .NUM_PTR(NUM_PTR), .CLUSTER(CLUSTER), .OVF(OVF)) u_next (
    .mode_i (mode_q[cmd_idx_i]), .vld_i (vld_q[cmd_idx_i]), .word_i (word_q[cmd_idx_i]),
    .rr_i   (rr_q[cmd_idx_i]),   .op_i  (op_e'(cmd_op_i)),  .proc_i (cmd_proc_i),
    .mode_o (n_mode), .vld_o (n_vld), .word_o (n_word), .rr_o (n_rr),
    .emit_o (emit),   .mask_o (mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NUM_ENTRY; e++) begin
        mode_q[e] <= 1'b0; vld_q[e] <= '0; word_q[e] <= '0; rr_q[e] <= '0;
      end
    end else if (acc) begin
      mode_q[cmd_idx_i] <= n_mode;
      vld_q[cmd_idx_i]  <= n_vld;
      word_q[cmd_idx_i] <= n_word;
      rr_q[cmd_idx_i]   <= n_rr;
    end
  end

  dir_inv_emit #(.NUM_PROC(NUM_PROC)) u_emit (
    .clk_i, .rst_ni, .start_i (acc && emit), .mask_i (mask), .busy_o (busy),
    .inv_valid_o, .inv_ready_i, .inv_proc_o, .done_o (inv_done_o)
  );
endmodule

// File: rtl/dir_limptr_chk.sv
module dir_limptr_chk #(
  parameter int unsigned LG = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          cmd_ready_o,
  input logic [1:0]    cmd_op_i,
  input logic          inv_valid_o,
  input logic          inv_ready_i,
  input logic [LG-1:0] inv_proc_o,
  input logic          inv_done_o
);
  always @(posedge clk_i)
    if (!rst_ni)
      a_r1_reset_idle: assert (cmd_ready_o && !inv_valid_o && !inv_done_o);

  a_r8_hold_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o && !inv_ready_i |=> inv_valid_o && $stable(inv_proc_o));

  a_r8_busy_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o || inv_done_o |-> !cmd_ready_o);

  a_r8_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && cmd_op_i == 2'd3 |=> !cmd_ready_o);

  a_r4_done_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_done_o |-> !inv_valid_o);

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_done_o |=> !inv_done_o);

  a_r4_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o && inv_ready_i |=> !inv_valid_o || inv_proc_o > $past(inv_proc_o));
endmodule

bind dir_limptr dir_limptr_chk #(.LG(LG)) u_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_op_i,
  .inv_valid_o, .inv_ready_i, .inv_proc_o, .inv_done_o
);

// File: tb/dir_limptr_bench.sv
module dir_limptr_bench;
  import dir_pkg::*;
  localparam int ND = 3;
  localparam logic [1:0] OA = 2'd1, OR = 2'd2, OW = 2'd3;

  typedef struct packed {
    logic [1:0] dut; logic [1:0] op; logic [2:0] idx; logic [3:0] proc;
    logic em; logic [15:0] mask; logic [3:0] req;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VEC [NV] = '{
    // dut 0: group-vector overflow
    '{2'd0, OW, 3'd0, 4'd3,  1'b1, 16'h0000, 4'd1},  // R1 empty after reset
    '{2'd0, OA, 3'd0, 4'd5,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd0, 4'd5,  1'b0, 16'h0000, 4'd2},  // R2 duplicate
    '{2'd0, OA, 3'd0, 4'd9,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OW, 3'd0, 4'd9,  1'b1, 16'h0028, 4'd4},  // R4 writer excluded
    '{2'd0, OW, 3'd0, 4'd9,  1'b1, 16'h0000, 4'd4},
    '{2'd0, OW, 3'd0, 4'd4,  1'b1, 16'h0200, 4'd4},
    '{2'd0, OA, 3'd1, 4'd1,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd1, 4'd2,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd1, 4'd6,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd1, 4'd12, 1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd1, 4'd13, 1'b0, 16'h0000, 4'd5},  // R5 overflow
    '{2'd0, OW, 3'd1, 4'd0,  1'b1, 16'hF0FE, 4'd5},
    '{2'd0, OA, 3'd2, 4'd0,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd2, 4'd1,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd2, 4'd2,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd2, 4'd3,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd2, 4'd4,  1'b0, 16'h0000, 4'd5},
    '{2'd0, OA, 3'd2, 4'd9,  1'b0, 16'h0000, 4'd5},  // R5 add in group mode
    '{2'd0, OR, 3'd2, 4'd4,  1'b0, 16'h0000, 4'd5},  // R5 remove ignored
    '{2'd0, OW, 3'd2, 4'd15, 1'b1, 16'h0FFF, 4'd5},
    '{2'd0, OA, 3'd3, 4'd7,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd3, 4'd8,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OR, 3'd3, 4'd7,  1'b0, 16'h0000, 4'd3},  // R3
    '{2'd0, OR, 3'd3, 4'd11, 1'b0, 16'h0000, 4'd3},
    '{2'd0, OW, 3'd3, 4'd2,  1'b1, 16'h0100, 4'd3},
    '{2'd0, OA, 3'd4, 4'd1,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd4, 4'd2,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd4, 4'd3,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OA, 3'd4, 4'd4,  1'b0, 16'h0000, 4'd2},
    '{2'd0, OR, 3'd4, 4'd2,  1'b0, 16'h0000, 4'd3},
    '{2'd0, OA, 3'd4, 4'd5,  1'b0, 16'h0000, 4'd3},  // R3 slot reused
    '{2'd0, OW, 3'd4, 4'd0,  1'b1, 16'h003A, 4'd3},
    '{2'd0, OW, 3'd5, 4'd1,  1'b1, 16'h0000, 4'd9},  // R9 untouched entry
    '{2'd0, OW, 3'd1, 4'd3,  1'b1, 16'h0001, 4'd9},
    // dut 1: replacement
    '{2'd1, OA, 3'd0, 4'd1,  1'b0, 16'h0000, 4'd2},
    '{2'd1, OA, 3'd0, 4'd2,  1'b0, 16'h0000, 4'd2},
    '{2'd1, OA, 3'd0, 4'd3,  1'b0, 16'h0000, 4'd2},
    '{2'd1, OA, 3'd0, 4'd4,  1'b0, 16'h0000, 4'd2},
    '{2'd1, OA, 3'd0, 4'd3,  1'b0, 16'h0000, 4'd6},  // R6 duplicate, no eviction
    '{2'd1, OA, 3'd0, 4'd5,  1'b1, 16'h0002, 4'd6},
    '{2'd1, OA, 3'd0, 4'd6,  1'b1, 16'h0004, 4'd6},
    '{2'd1, OW, 3'd0, 4'd15, 1'b1, 16'h0078, 4'd6},
    '{2'd1, OA, 3'd0, 4'd1,  1'b0, 16'h0000, 4'd6},
    '{2'd1, OA, 3'd0, 4'd2,  1'b0, 16'h0000, 4'd6},
    '{2'd1, OA, 3'd0, 4'd3,  1'b0, 16'h0000, 4'd6},
    '{2'd1, OA, 3'd0, 4'd4,  1'b1, 16'h8000, 4'd6},  // R6 index back at slot 0
    '{2'd1, OW, 3'd0, 4'd0,  1'b1, 16'h001E, 4'd6},
    // dut 2: broadcast
    '{2'd2, OA, 3'd0, 4'd1,  1'b0, 16'h0000, 4'd2},
    '{2'd2, OA, 3'd0, 4'd2,  1'b0, 16'h0000, 4'd2},
    '{2'd2, OA, 3'd0, 4'd3,  1'b0, 16'h0000, 4'd2},
    '{2'd2, OA, 3'd0, 4'd4,  1'b0, 16'h0000, 4'd2},
    '{2'd2, OA, 3'd0, 4'd5,  1'b0, 16'h0000, 4'd7},  // R7
    '{2'd2, OA, 3'd0, 4'd9,  1'b0, 16'h0000, 4'd7},
    '{2'd2, OW, 3'd0, 4'd7,  1'b1, 16'hFF7F, 4'd7},
    '{2'd2, OW, 3'd0, 4'd0,  1'b1, 16'h0080, 4'd7}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cv [ND], ir [ND], cr [ND], iv [ND], dn [ND];
  logic [1:0] cop [ND];
  logic [2:0] cidx [ND];
  logic [3:0] cpr [ND], ip [ND];
  int total = 0, bad = 0;

  dir_limptr #(.OVF(OVF_COARSE)) u_dir_limptr (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv[0]), .cmd_ready_o(cr[0]), .cmd_op_i(cop[0]),
    .cmd_idx_i(cidx[0]), .cmd_proc_i(cpr[0]), .inv_valid_o(iv[0]), .inv_ready_i(ir[0]),
    .inv_proc_o(ip[0]), .inv_done_o(dn[0]));
  dir_limptr #(.OVF(OVF_REPLACE)) u_dir_limptr_rep (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv[1]), .cmd_ready_o(cr[1]), .cmd_op_i(cop[1]),
    .cmd_idx_i(cidx[1]), .cmd_proc_i(cpr[1]), .inv_valid_o(iv[1]), .inv_ready_i(ir[1]),
    .inv_proc_o(ip[1]), .inv_done_o(dn[1]));
  dir_limptr #(.OVF(OVF_BCAST)) u_dir_limptr_bc (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv[2]), .cmd_ready_o(cr[2]), .cmd_op_i(cop[2]),
    .cmd_idx_i(cidx[2]), .cmd_proc_i(cpr[2]), .inv_valid_o(iv[2]), .inv_ready_i(ir[2]),
    .inv_proc_o(ip[2]), .inv_done_o(dn[2]));

  task automatic check(input logic ok, input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input int d, input logic [1:0] op, input logic [2:0] idx, input logic [3:0] pr);
    @(negedge clk); cv[d] = 1'b1; cop[d] = op; cidx[d] = idx; cpr[d] = pr;
    @(negedge clk); cv[d] = 1'b0;
  endtask

  task automatic collect(input int d, output logic [15:0] obs, output logic ok);
    logic have = 1'b0, done = 1'b0, ord = 1'b1;
    logic [3:0] last = '0;
    obs = '0;
    for (int c = 0; c < 40; c++) begin
      if (dn[d]) begin done = 1'b1; break; end
      if (iv[d]) begin
        if (have && ip[d] <= last) ord = 1'b0;
        last = ip[d]; have = 1'b1; obs[ip[d]] = 1'b1;
      end
      @(negedge clk);
    end
    ok = done && ord;
  endtask

  task automatic quiet(input int d, output logic ok);
    ok = 1'b1;
    for (int c = 0; c < 2; c++) begin
      if (iv[d] || dn[d]) ok = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog: actual=%h expected=%h", 16'h0, 16'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] obs;
    logic ok;
    for (int d = 0; d < ND; d++) begin
      cv[d] = 1'b0; ir[d] = 1'b1; cop[d] = '0; cidx[d] = '0; cpr[d] = '0;
    end
    repeat (3) @(negedge clk);
    for (int d = 0; d < ND; d++)   // R1 outputs during reset
      check(cr[d] && !iv[d] && !dn[d], 1, "idle in reset", {13'd0, cr[d], iv[d], dn[d]}, 16'h4);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < ND; d++)   // R1 after release
      check(cr[d] && !iv[d] && !dn[d], 1, "idle after reset", {13'd0, cr[d], iv[d], dn[d]}, 16'h4);

    for (int v = 0; v < NV; v++) begin
      send(int'(VEC[v].dut), VEC[v].op, VEC[v].idx, VEC[v].proc);
      if (VEC[v].em) begin
        collect(int'(VEC[v].dut), obs, ok);
        check(ok && obs == VEC[v].mask, int'(VEC[v].req), $sformatf("vec %0d targets", v), obs, VEC[v].mask);
      end else begin
        quiet(int'(VEC[v].dut), ok);
        check(ok, int'(VEC[v].req), $sformatf("vec %0d silent", v), {15'd0, !ok}, 16'h0);
      end
    end

    // R8 back-pressure on a write
    send(0, OA, 3'd6, 4'd1);
    send(0, OA, 3'd6, 4'd2);
    ir[0] = 1'b0;
    send(0, OW, 3'd6, 4'd0);
    check(iv[0] && ip[0] == 4'd1 && !cr[0], 8, "first target while stalled",
          {11'd0, iv[0], ip[0]}, 16'h0011);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(iv[0] && ip[0] == 4'd1 && !cr[0], 8, "target held", {11'd0, iv[0], ip[0]}, 16'h0011);
    end
    ir[0] = 1'b1;
    collect(0, obs, ok);
    check(ok && obs == 16'h0006, 8, "targets after stall", obs, 16'h0006);

    // R1 reset during use clears entries
    send(0, OA, 3'd7, 4'd5);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    send(0, OW, 3'd7, 4'd0);
    collect(0, obs, ok);
    check(ok && obs == 16'h0000, 1, "entry empty after reset", obs, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule